// File: doc/BRIEF.md
# Four-Tap Streaming FIR with Valid Tracking

This block filters a stream of 4-bit unsigned samples with fixed weights of one, three, two and one. The live sample and the three before it are multiplied by their weights, summed and registered into a 10-bit result. Downstream logic reads the result only while its qualifier is high.

A valid bit moves through the delay stages beside each stored sample. The result is marked valid only when every tap holds a real sample. Start-up cycles, and cycles whose window contains a gap in the input stream, are therefore never presented as meaningful data.

The reset input is active low. Asserting it clears the block at once. Its release is synchronized to the clock inside the block.

Top module: `fir4_stream`

## Requirements
- R1: When `res_vld` is high, `res_out` equals x[n] + 3·x[n-1] + 2·x[n-2] + x[n-3]. Here x[n] is the sample captured at the most recent rising edge and x[n-1] to x[n-3] are the samples captured at the three edges before it. The sum uses unsigned arithmetic and is zero-extended to 10 bits.
- R2: The result that includes a sample appears on `res_out` after the same rising edge that captures the sample, through one output register. Its valid flag appears in the same cycle.
- R3: `res_vld` is high after an edge only if `smp_vld` was high at that edge and at each of the three edges before it.
- R4: After reset is released, `res_vld` stays low until four consecutive valid samples have been captured.
- R5: The delay line shifts on every edge, including edges where `smp_vld` is low. A low input-valid cycle forces `res_vld` low for the four results whose window contains it. Valid output resumes after four new consecutive valid samples.
- R6: `res_out` never exceeds 105 (15 × 7), so bits 9 to 7 are always zero.
- R7: While `rst_n` is low, `res_out` and `res_vld` are zero, with no clock edge needed. After `rst_n` rises, the block ignores the input at the first two rising edges. The third rising edge captures the first sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, released synchronously |
| smp_in | input | 4 | Unsigned input sample |
| smp_vld | input | 1 | High when `smp_in` carries a real sample |
| res_out | output | 10 | Registered filter result |
| res_vld | output | 1 | High when `res_out` is built from four real samples |

## Verification
Every result is due one register after the edge that captures its newest sample. The bench updates its own four-entry history at each rising edge and compares the outputs two time units after that edge. It drives new inputs only at falling edges.

After each reset release, the bench model inserts two empty entries into its history to account for the two ignored edges. The first valid output is therefore expected after the sixth edge. The bench also checks the asynchronous clear one time unit after `rst_n` falls, in the middle of a cycle, before any clock edge.

// File: rtl/fir4_pkg.sv
package fir4_pkg;
  localparam int SMP_W  = 4;
  localparam int NTAP   = 4;
  localparam int COEF_W = SMP_W;
  localparam int ACC_W  = 10;
  localparam int SYNC_STAGES = 2;

  // fixed weights, index 0 = live sample
  function automatic logic [COEF_W-1:0] tap_coef(input int idx);
    logic [COEF_W-1:0] c;
    case (idx)
      0:       c = COEF_W'(1);
      1:       c = COEF_W'(3);
      2:       c = COEF_W'(2);
      default: c = COEF_W'(1);
    endcase
    return c;
  endfunction
endpackage

// File: rtl/fir4_rst_sync.sv
module fir4_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/fir4_delay.sv
module fir4_delay #(
  parameter int W     = 4,
  parameter int DEPTH = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [W-1:0]           din,
  input  logic                   vin,
  output logic [DEPTH:0][W-1:0]  taps,
  output logic [DEPTH:0]         tvld
);
  logic [DEPTH-1:0][W-1:0] stg_q, stg_d;
  logic [DEPTH-1:0]        vld_q, vld_d;
  logic                    shift_en;

  assign shift_en = 1'b1;  // line advances every cycle, gaps included

  always_comb begin
    stg_d = stg_q;
    vld_d = vld_q;
    if (shift_en) begin
      stg_d[0] = din;
      vld_d[0] = vin;
      for (int i = 1; i < DEPTH; i++) begin
        stg_d[i] = stg_q[i-1];
        vld_d[i] = vld_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      vld_q <= '0;
    end else begin
      stg_q <= stg_d;
      vld_q <= vld_d;
    end
  end

  assign taps = {stg_q, din};
  assign tvld = {vld_q, vin};
endmodule

// File: rtl/fir4_mac.sv
module fir4_mac #(
  parameter int W     = 4,
  parameter int NT    = 4,
  parameter int OUT_W = 10
) (
  input  logic [NT-1:0][W-1:0] taps,
  output logic [OUT_W-1:0]     sum
);
  localparam int PW = 2 * W;

  logic [NT-1:0][PW-1:0] prod;

  for (genvar g = 0; g < NT; g++) begin : g_tap
    assign prod[g] = PW'(taps[g]) * PW'(fir4_pkg::tap_coef(g));
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NT; i++) begin
      sum = sum + OUT_W'(prod[i]);
    end
  end
endmodule

// File: rtl/fir4_stream.sv
module fir4_stream #(
  parameter int SMP_W = fir4_pkg::SMP_W,
  parameter int OUT_W = fir4_pkg::ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] smp_in,
  input  logic             smp_vld,
  output logic [OUT_W-1:0] res_out,
  output logic             res_vld
);
  localparam int NT    = fir4_pkg::NTAP;
  localparam int DEPTH = NT - 1;

  logic                      rst_n_s;
  logic [DEPTH:0][SMP_W-1:0] taps;
  logic [DEPTH:0]            tvld;
  logic [OUT_W-1:0]          sum;
  logic [OUT_W-1:0]          out_d, out_q;
  logic                      vld_d, vld_q;
  logic                      out_en;

  fir4_rst_sync #(.STAGES(fir4_pkg::SYNC_STAGES)) u_rsync (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  fir4_delay #(.W(SMP_W), .DEPTH(DEPTH)) u_dly (
    .clk   (clk),
    .rst_n (rst_n_s),
    .din   (smp_in),
    .vin   (smp_vld),
    .taps  (taps),
    .tvld  (tvld)
  );

  fir4_mac #(.W(SMP_W), .NT(NT), .OUT_W(OUT_W)) u_mac (
    .taps (taps),
    .sum  (sum)
  );

  assign out_en = 1'b1;

  always_comb begin
    out_d = out_q;
    vld_d = vld_q;
    if (out_en) begin
      out_d = sum;
      vld_d = &tvld;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      out_q <= out_d;
      vld_q <= vld_d;
    end
  end

  assign res_out = out_q;
  assign res_vld = vld_q;
endmodule

// File: rtl/fir4_chk.sv
module fir4_chk #(
  parameter int SMP_W = 4,
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SMP_W-1:0] smp_in,
  input logic             smp_vld,
  input logic [OUT_W-1:0] res_out,
  input logic             res_vld
);
  AST_VLD_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> ($past(smp_vld, 1) && $past(smp_vld, 2) && $past(smp_vld, 3) && $past(smp_vld, 4))); // R3

  AST_GAP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_vld, 1) |-> !res_vld); // R5

  AST_SUM_TAPS: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (res_out == OUT_W'($past(smp_in, 1)) + OUT_W'(3) * OUT_W'($past(smp_in, 2))
                 + OUT_W'(2) * OUT_W'($past(smp_in, 3)) + OUT_W'($past(smp_in, 4)))); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    res_out <= OUT_W'(105)); // R6

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RST_CLEAR: assert (!res_vld && res_out == '0); // R7
    end
  end
endmodule

bind fir4_stream fir4_chk #(.SMP_W(SMP_W), .OUT_W(OUT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .smp_in  (smp_in),
  .smp_vld (smp_vld),
  .res_out (res_out),
  .res_vld (res_vld)
);

// File: tb/sim_fir4_stream.sv
module sim_fir4_stream;
  localparam int W  = 4;
  localparam int OW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  smp_in = '0;
  logic          smp_vld = 1'b0;
  logic [OW-1:0] res_out;
  logic          res_vld;

  always #10 clk = ~clk;

  fir4_stream u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_in  (smp_in),
    .smp_vld (smp_vld),
    .res_out (res_out),
    .res_vld (res_vld)
  );

  int n_chk = 0;
  int n_bad = 0;
  int hold  = 0;
  int hx[4];
  bit hv[4];

  function automatic int exp_sum();
    return hx[0] + 3 * hx[1] + 2 * hx[2] + hx[3];
  endfunction

  function automatic bit exp_vld();
    return hv[0] & hv[1] & hv[2] & hv[3];
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 4; i++) begin
      hx[i] = 0;
      hv[i] = 1'b0;
    end
    hold = 2;  // R7: two ignored edges after release
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(int x, bit v, string tag);
    smp_in  = W'(x);
    smp_vld = v;
    @(posedge clk);
    for (int i = 3; i > 0; i--) begin
      hx[i] = hx[i-1];
      hv[i] = hv[i-1];
    end
    if (hold > 0) begin
      hx[0] = 0;
      hv[0] = 1'b0;
      hold--;
    end else begin
      hx[0] = x;
      hv[0] = v;
    end
    #2;
    check({tag, " res_vld"}, int'(res_vld), int'(exp_vld()));
    if (exp_vld()) begin
      check("R1 R2 res_out", int'(res_out), exp_sum());
      check("R6 bound", int'(res_out <= OW'(105)), 1);
    end
    @(negedge clk);
  endtask

  task automatic async_reset();
    #3 rst_n = 1'b0;
    #1;
    check("R7 async clear res_vld", int'(res_vld), 0);
    check("R7 async clear res_out", int'(res_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    clear_model();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #4000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    clear_model();
    repeat (3) @(negedge clk);
    check("R7 reset res_vld", int'(res_vld), 0);
    check("R7 reset res_out", int'(res_out), 0);
    rst_n = 1'b1;

    // R7 then R4: valid from the first edge after release
    for (int i = 0; i < 8; i++) step(i + 1, 1'b1, (i < 2) ? "R7" : "R4");

    // R6: full-scale samples
    for (int i = 0; i < 6; i++) step(15, 1'b1, "R6");
    for (int i = 0; i < 4; i++) step(0, 1'b1, "R1");

    // R5: one-cycle gap, then recovery
    for (int i = 0; i < 4; i++) step(5 + i, 1'b1, "R5");
    step(9, 1'b0, "R5");
    for (int i = 0; i < 6; i++) step(2 * i + 1, 1'b1, "R5");

    // R3: random stream with sparse gaps
    for (int i = 0; i < 300; i++) begin
      int x = int'($urandom % 16);
      bit v = (($urandom % 8) != 0);
      step(x, v, "R3");
    end

    // R7: reset in mid-stream
    async_reset();
    for (int i = 0; i < 8; i++) step(int'($urandom % 16), 1'b1, "R7");

    // R2: more random traffic
    for (int i = 0; i < 200; i++) begin
      int x = int'($urandom % 16);
      bit v = (($urandom % 6) != 0);
      step(x, v, "R2");
    end

    summary();
    $finish;
  end
endmodule